// File: doc/BRIEF.md
# Host Buffer Access Guard

This block sits beside the host-facing staging buffers of a message memory. It watches every host write to the input staging buffer and every request that moves a message buffer, or a receive-FIFO entry, into the output staging buffer. A request that breaks an access rule is not forwarded: the matching transfer-enable output stays low in that same cycle. The block also records the violation in a sticky error flag.

Whether a request is legal depends on several inputs:
- the busy flag of the buffer side concerned;
- whether the controller is in a configuration state;
- a two-bit security mode;
- a boundary buffer number that separates static from dynamic buffers;
- the key-slot transmit setting of buffers 0 and 1;
- a map of which buffers belong to the receive FIFO.

The block also holds a flag for receive-FIFO overruns, which the next host FIFO read clears. Each flag has an enable bit. The interrupt output combines the enabled flags.

The flag vector `flags` uses these bits:
- bit 0: illegal output-buffer access;
- bit 1: illegal input-buffer access;
- bit 2: empty-FIFO access;
- bit 3: FIFO overrun.

Top module: `hbuf_access_guard`

## Requirements
- R1: An output request (`ob_req`) while `ob_busy` is 1 keeps `ob_xfer_en` low in that cycle and sets `flags[0]` at the next clock edge.
- R2: Any host input-buffer write (`ib_reg_wr` or `ib_cmd_wr`) while `ib_busy` is 1 sets `flags[1]` at the next edge, and `ib_xfer_en` stays low.
- R3: Outside configuration (`cfg_state`=0), a header change (`ib_sel_hdr`=1) of buffer 0 or 1 whose `key_slot` bit is 1 is illegal.
- R4: Outside configuration with `sec_mode`=01, a header change of a buffer whose number is below `first_dyn` is illegal. Buffers at or above `first_dyn` are not restricted by this mode.
- R5: Outside configuration with `sec_mode`=10 or 11, every header change is illegal. A data-only change is not restricted by this mode.
- R6: Outside configuration, a change to the header or the data of a buffer whose `fifo_map` bit is 1 is illegal. A command that selects neither section is legal.
- R7: In configuration (`cfg_state`=1), only the busy rule of R2 applies. Every illegal input command sets `flags[1]`, and every legal one raises `ib_xfer_en` in the same cycle.
- R8: An output request with `ob_from_fifo`=1 while `fifo_empty`=1 sets `flags[2]` and keeps `ob_xfer_en` low.
- R9: A `fifo_overrun` pulse sets `flags[3]`. A later `fifo_rd` clears it. An overrun and a read in the same cycle leave it set.
- R10: Writing 1 through `clr_wr`/`clr_data` clears the matching flag. Writing 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R11: `irq` equals the OR over all bits of `flags & irq_en`.
- R12: After reset all flags, `irq` and both transfer enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ib_reg_wr | input | 1 | Host write to any input-buffer register |
| ib_cmd_wr | input | 1 | Host write of the input transfer command |
| ib_buf_num | input | BUF_W | Target buffer number of the command |
| ib_sel_hdr | input | 1 | Command changes the header section |
| ib_sel_data | input | 1 | Command changes the data section |
| ib_busy | input | 1 | Input-side transfer in progress |
| ob_req | input | 1 | Host requests a transfer into the output buffer |
| ob_from_fifo | input | 1 | Request takes the next receive-FIFO entry |
| ob_busy | input | 1 | Output-side transfer in progress |
| cfg_state | input | 1 | Controller is in a configuration state |
| key_slot | input | 2 | Key-slot transmit setting of buffers 0 and 1 |
| first_dyn | input | FD_W | First dynamic buffer number |
| sec_mode | input | 2 | Security mode |
| fifo_map | input | NBUF | One bit per buffer: member of receive FIFO |
| fifo_empty | input | 1 | Receive FIFO is empty |
| fifo_overrun | input | 1 | Overrun event pulse |
| fifo_rd | input | 1 | Host FIFO read strobe |
| clr_wr | input | 1 | Host write to the flag register |
| clr_data | input | 4 | Write-one-to-clear data |
| irq_en | input | 4 | Per-flag interrupt enable |
| flags | output | 4 | Sticky error flags |
| irq | output | 1 | Combined interrupt |
| ib_xfer_en | output | 1 | Legal input command forwarded |
| ob_xfer_en | output | 1 | Legal output request forwarded |

## Verification
Two pairs of events can fall in the same cycle:
- A rule violation and the host's write-one-to-clear of the same flag. The bench provokes this by repeating an output request while the output side is busy, with the clear of bit 0 asserted in that same cycle.
- A FIFO overrun and a host FIFO read. The bench drives both strobes together.

In both cases the flag must read 1 at the following sampling point. Once the bench removes the event, a plain clear or read must take the flag to 0.

// File: rtl/hbuf_guard_pkg.sv
package hbuf_guard_pkg;
   localparam int FLAG_N       = 4;
   localparam int F_OB_ILL     = 0;
   localparam int F_IB_ILL     = 1;
   localparam int F_FIFO_EMPTY = 2;
   localparam int F_FIFO_OVR   = 3;

   typedef enum logic [1:0] {
      SEC_OPEN   = 2'b00,
      SEC_STATIC = 2'b01,
      SEC_ALL_A  = 2'b10,
      SEC_ALL_B  = 2'b11
   } sec_mode_e;

   typedef struct packed {
      logic hdr;
      logic data;
   } section_t;
endpackage

// File: rtl/hbuf_ib_rules.sv
module hbuf_ib_rules
   import hbuf_guard_pkg::*;
#(
   parameter int NBUF  = 8,
   parameter int BUF_W = 3,
   parameter int FD_W  = 4,
   parameter int KEYS  = 2
) (
   input  logic             reg_wr,
   input  logic             cmd_wr,
   input  logic             busy,
   input  logic             cfg,
   input  logic [BUF_W-1:0] buf_num,
   input  section_t         sect,
   input  logic [KEYS-1:0]  key_slot,
   input  logic [FD_W-1:0]  first_dyn,
   input  sec_mode_e        mode,
   input  logic [NBUF-1:0]  fifo_map,
   output logic             illegal,
   output logic             xfer_en
);
   logic [KEYS-1:0] key_vec;
   logic [NBUF-1:0] fifo_vec;
   logic            key_hit, static_hit, all_hit, fifo_hit, busy_hit, state_hit;

   for (genvar k = 0; k < KEYS; k++) begin : g_key
      assign key_vec[k] = key_slot[k] && (buf_num == BUF_W'(k));
   end

   for (genvar i = 0; i < NBUF; i++) begin : g_fifo
      assign fifo_vec[i] = fifo_map[i] && (buf_num == BUF_W'(i));
   end

   always_comb begin
      busy_hit   = (reg_wr || cmd_wr) && busy;
      key_hit    = sect.hdr && (|key_vec);
      static_hit = sect.hdr && (mode == SEC_STATIC) && (FD_W'(buf_num) < first_dyn);
      all_hit    = sect.hdr && (mode == SEC_ALL_A || mode == SEC_ALL_B);
      fifo_hit   = (sect.hdr || sect.data) && (|fifo_vec);
      state_hit  = cmd_wr && !cfg && (key_hit || static_hit || all_hit || fifo_hit);
      illegal    = busy_hit || state_hit;
      xfer_en    = cmd_wr && !illegal;
   end
endmodule

// File: rtl/hbuf_ob_rules.sv
module hbuf_ob_rules (
   input  logic req,
   input  logic from_fifo,
   input  logic busy,
   input  logic fifo_empty,
   output logic busy_hit,
   output logic empty_hit,
   output logic xfer_en
);
   always_comb begin
      busy_hit  = req && busy;
      empty_hit = req && from_fifo && fifo_empty;
      xfer_en   = req && !busy_hit && !empty_hit;
   end
endmodule

// File: rtl/hbuf_flag_cell.sv
module hbuf_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end
endmodule

// File: rtl/hbuf_flag_bank.sv
module hbuf_flag_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_v,
   input  logic [N-1:0] clr_v,
   output logic [N-1:0] q
);
   for (genvar f = 0; f < N; f++) begin : g_cell
      hbuf_flag_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_v[f]),
         .clr_i (clr_v[f]),
         .q     (q[f])
      );
   end
endmodule

// File: rtl/hbuf_access_guard.sv
module hbuf_access_guard
   import hbuf_guard_pkg::*;
#(
   parameter int NBUF         = 8,
   parameter bit OVR_HOST_CLR = 1'b1,
   localparam int BUF_W       = (NBUF > 1) ? $clog2(NBUF) : 1,
   localparam int FD_W        = $clog2(NBUF + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ib_reg_wr,
   input  logic              ib_cmd_wr,
   input  logic [BUF_W-1:0]  ib_buf_num,
   input  logic              ib_sel_hdr,
   input  logic              ib_sel_data,
   input  logic              ib_busy,
   input  logic              ob_req,
   input  logic              ob_from_fifo,
   input  logic              ob_busy,
   input  logic              cfg_state,
   input  logic [1:0]        key_slot,
   input  logic [FD_W-1:0]   first_dyn,
   input  logic [1:0]        sec_mode,
   input  logic [NBUF-1:0]   fifo_map,
   input  logic              fifo_empty,
   input  logic              fifo_overrun,
   input  logic              fifo_rd,
   input  logic              clr_wr,
   input  logic [FLAG_N-1:0] clr_data,
   input  logic [FLAG_N-1:0] irq_en,
   output logic [FLAG_N-1:0] flags,
   output logic              irq,
   output logic              ib_xfer_en,
   output logic              ob_xfer_en
);
   if (NBUF < 2 || NBUF > 256) begin : g_bad_nbuf
      $error("hbuf_access_guard: NBUF must lie in 2..256");
   end
   if (FD_W <= BUF_W - 1) begin : g_bad_fdw
      $error("hbuf_access_guard: boundary width too narrow");
   end

   logic              ib_illegal, ob_busy_hit, ob_empty_hit;
   logic [FLAG_N-1:0] set_v, clr_v;
   section_t          sect;

   assign sect = '{hdr: ib_sel_hdr, data: ib_sel_data};

   hbuf_ib_rules #(
      .NBUF (NBUF),
      .BUF_W(BUF_W),
      .FD_W (FD_W),
      .KEYS (2)
   ) u_ib (
      .reg_wr   (ib_reg_wr),
      .cmd_wr   (ib_cmd_wr),
      .busy     (ib_busy),
      .cfg      (cfg_state),
      .buf_num  (ib_buf_num),
      .sect     (sect),
      .key_slot (key_slot),
      .first_dyn(first_dyn),
      .mode     (sec_mode_e'(sec_mode)),
      .fifo_map (fifo_map),
      .illegal  (ib_illegal),
      .xfer_en  (ib_xfer_en)
   );

   hbuf_ob_rules u_ob (
      .req       (ob_req),
      .from_fifo (ob_from_fifo),
      .busy      (ob_busy),
      .fifo_empty(fifo_empty),
      .busy_hit  (ob_busy_hit),
      .empty_hit (ob_empty_hit),
      .xfer_en   (ob_xfer_en)
   );

   assign set_v[F_OB_ILL]     = ob_busy_hit;
   assign set_v[F_IB_ILL]     = ib_illegal;
   assign set_v[F_FIFO_EMPTY] = ob_empty_hit;
   assign set_v[F_FIFO_OVR]   = fifo_overrun;

   for (genvar f = 0; f < FLAG_N; f++) begin : g_clr
      if (f == F_FIFO_OVR) begin : g_rd_clear
         if (OVR_HOST_CLR) begin : g_both
            assign clr_v[f] = fifo_rd || (clr_wr && clr_data[f]);
         end else begin : g_rd_only
            assign clr_v[f] = fifo_rd || (1'b0 && clr_data[f]);
         end
      end else begin : g_w1c
         assign clr_v[f] = clr_wr && clr_data[f];
      end
   end

   hbuf_flag_bank #(.N(FLAG_N)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .set_v(set_v),
      .clr_v(clr_v),
      .q    (flags)
   );

   assign irq = |(flags & irq_en);
endmodule

// File: rtl/hbuf_guard_chk.sv
module hbuf_guard_chk #(
   parameter int NBUF  = 8,
   parameter int BUF_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ib_reg_wr,
   input logic             ib_cmd_wr,
   input logic [BUF_W-1:0] ib_buf_num,
   input logic             ib_sel_hdr,
   input logic             ib_sel_data,
   input logic             ib_busy,
   input logic             ob_req,
   input logic             ob_from_fifo,
   input logic             ob_busy,
   input logic             cfg_state,
   input logic [NBUF-1:0]  fifo_map,
   input logic             fifo_empty,
   input logic             fifo_overrun,
   input logic             fifo_rd,
   input logic             clr_wr,
   input logic [3:0]       clr_data,
   input logic [3:0]       irq_en,
   input logic [3:0]       flags,
   input logic             irq,
   input logic             ib_xfer_en,
   input logic             ob_xfer_en
);
   p_ob_busy_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ob_req && ob_busy |-> !ob_xfer_en);
   p_ob_busy_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ob_req && ob_busy |=> flags[0]);
   p_ib_busy_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ib_reg_wr || ib_cmd_wr) && ib_busy |=> flags[1]);
   p_ib_fwd_needs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ib_xfer_en |-> ib_cmd_wr && !ib_busy);
   p_fifo_member_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ib_cmd_wr && !cfg_state && fifo_map[ib_buf_num] && (ib_sel_hdr || ib_sel_data)
      |-> !ib_xfer_en);
   p_empty_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ob_req && ob_from_fifo && fifo_empty |=> flags[2] && !$past(ob_xfer_en));
   p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_overrun |=> flags[3]);
   p_ovr_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd && !fifo_overrun |=> !flags[3]);
   p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flags[0] && !(clr_wr && clr_data[0]) |=> flags[0]);
   p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en == 4'b0000 |-> !irq);
   p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags != 4'b0000));
endmodule

bind hbuf_access_guard hbuf_guard_chk #(.NBUF(NBUF), .BUF_W(BUF_W)) u_chk (.*);

// File: tb/tb_hbuf_access_guard.sv
`timescale 1ns/1ps
module tb_hbuf_access_guard;
   localparam int NBUF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ib_reg_wr = 0, ib_cmd_wr = 0, ib_sel_hdr = 0, ib_sel_data = 0, ib_busy = 0;
   logic [2:0] ib_buf_num = '0;
   logic       ob_req = 0, ob_from_fifo = 0, ob_busy = 0, cfg_state = 0;
   logic [1:0] key_slot = '0, sec_mode = '0;
   logic [3:0] first_dyn = '0;
   logic [7:0] fifo_map = '0;
   logic       fifo_empty = 0, fifo_overrun = 0, fifo_rd = 0, clr_wr = 0;
   logic [3:0] clr_data = '0, irq_en = '0;
   logic [3:0] flags;
   logic       irq, ib_xfer_en, ob_xfer_en;

   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   hbuf_access_guard #(.NBUF(NBUF)) dut (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit ib_rule_ill(bit busy, bit rw, bit cw, bit cfg, int sec, int fd,
                                      int num, bit hdr, bit dat, logic [1:0] key, logic [7:0] fm);
      if ((rw || cw) && busy) return 1;
      if (!cw || cfg) return 0;
      if (hdr && num < 2 && key[num]) return 1;
      if (hdr && sec == 1 && num < fd) return 1;
      if (hdr && sec >= 2) return 1;
      if (fm[num] && (hdr || dat)) return 1;
      return 0;
   endfunction

   task automatic clear_all();
      @(negedge clk);
      clr_wr = 1; clr_data = 4'hF; fifo_rd = 1;
      @(negedge clk);
      clr_wr = 0; clr_data = 4'h0; fifo_rd = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      irq_en = 4'hF;
      repeat (3) @(negedge clk);
      // R12: reset values
      check(flags == 4'h0, "R12", flags, 0);
      check(irq == 1'b0, "R12", irq, 0);
      check(!ib_xfer_en && !ob_xfer_en, "R12", {ib_xfer_en, ob_xfer_en}, 0);
      rst_n = 1;
      @(negedge clk);
      check(flags == 4'h0, "R12", flags, 0);

      // R2..R7 sweep over input-side rules
      for (int cfg = 0; cfg < 2; cfg++)
      for (int sec = 0; sec < 4; sec++)
      for (int fdi = 0; fdi < 3; fdi++)
      for (int num = 0; num < NBUF; num++)
      for (int sc = 1; sc < 4; sc++)
      for (int key = 0; key < 4; key++)
      for (int fmi = 0; fmi < 2; fmi++)
      for (int bsy = 0; bsy < 2; bsy++) begin
         int    fd;
         bit    ill;
         string tag;
         fd = (fdi == 0) ? 0 : (fdi == 1) ? 3 : 8;
         @(negedge clk);
         cfg_state = 1'(cfg); sec_mode = 2'(sec); first_dyn = 4'(fd);
         ib_buf_num = 3'(num); ib_sel_hdr = sc[1]; ib_sel_data = sc[0];
         key_slot = 2'(key); fifo_map = fmi ? 8'hC4 : 8'h00; ib_busy = 1'(bsy);
         ib_cmd_wr = 1;
         ill = ib_rule_ill(bsy[0], 1'b0, 1'b1, cfg[0], sec, fd, num, sc[1], sc[0],
                           2'(key), fifo_map);
         if (bsy != 0)                     tag = "R2";
         else if (cfg != 0)                tag = "R7";
         else if (fifo_map[num])           tag = "R6";
         else if (sec >= 2)                tag = "R5";
         else if (sec == 1)                tag = "R4";
         else                              tag = "R3";
         #1;
         check(ib_xfer_en == !ill, tag, ib_xfer_en, !ill);
         @(negedge clk);
         ib_cmd_wr = 0; ib_busy = 0;
         check(flags == {2'b00, ill, 1'b0}, tag, flags, {ill, 1'b0});
         if (ill) begin
            clr_wr = 1; clr_data = 4'b0010;
            @(negedge clk);
            clr_wr = 0; clr_data = 4'b0000;
            check(flags == 4'h0, "R10", flags, 0);
         end
      end

      // R6: command selecting no section on a FIFO buffer is legal
      @(negedge clk);
      cfg_state = 0; sec_mode = 2'b11; fifo_map = 8'hFF; ib_buf_num = 3'd2;
      ib_sel_hdr = 0; ib_sel_data = 0; ib_cmd_wr = 1;
      #1 check(ib_xfer_en == 1'b1, "R6", ib_xfer_en, 1);
      @(negedge clk);
      ib_cmd_wr = 0; fifo_map = 8'h00; sec_mode = 0;
      check(flags == 4'h0, "R6", flags, 0);

      // R2: plain register write while busy
      @(negedge clk);
      ib_reg_wr = 1; ib_busy = 1;
      @(negedge clk);
      ib_reg_wr = 0; ib_busy = 0;
      check(flags == 4'b0010, "R2", flags, 2);
      clear_all();
      @(negedge clk);
      ib_reg_wr = 1;
      @(negedge clk);
      ib_reg_wr = 0;
      check(flags == 4'b0000, "R2", flags, 0);

      // R1 / R8 sweep over output-side requests
      for (int v = 0; v < 16; v++) begin
         bit eb, ee, en;
         @(negedge clk);
         ob_req = v[0]; ob_busy = v[1]; ob_from_fifo = v[2]; fifo_empty = v[3];
         eb = v[0] && v[1];
         ee = v[0] && v[2] && v[3];
         en = v[0] && !eb && !ee;
         #1;
         check(ob_xfer_en == en, "R1", ob_xfer_en, en);
         @(negedge clk);
         ob_req = 0;
         check(flags[0] == eb, "R1", flags[0], eb);
         check(flags[2] == ee, "R8", flags[2], ee);
         clear_all();
      end
      ob_busy = 0; ob_from_fifo = 0; fifo_empty = 0;

      // R10: set and clear in same cycle, write of 0, plain clear
      @(negedge clk);
      ob_req = 1; ob_busy = 1;
      @(negedge clk);
      clr_wr = 1; clr_data = 4'b0001;
      @(negedge clk);
      ob_req = 0; ob_busy = 0; clr_wr = 0; clr_data = 0;
      check(flags[0] == 1'b1, "R10", flags[0], 1);
      @(negedge clk);
      clr_wr = 1; clr_data = 4'b1110;
      @(negedge clk);
      clr_wr = 0; clr_data = 0;
      check(flags[0] == 1'b1, "R10", flags[0], 1);
      @(negedge clk);
      clr_wr = 1; clr_data = 4'b0001;
      @(negedge clk);
      clr_wr = 0; clr_data = 0;
      check(flags[0] == 1'b0, "R10", flags[0], 0);

      // R9: overrun set, read clear, simultaneous event and read
      @(negedge clk);
      fifo_overrun = 1;
      @(negedge clk);
      fifo_overrun = 0;
      check(flags[3] == 1'b1, "R9", flags[3], 1);
      repeat (3) @(negedge clk);
      check(flags[3] == 1'b1, "R9", flags[3], 1);
      fifo_rd = 1; fifo_overrun = 1;
      @(negedge clk);
      fifo_overrun = 0; fifo_rd = 0;
      check(flags[3] == 1'b1, "R9", flags[3], 1);
      fifo_rd = 1;
      @(negedge clk);
      fifo_rd = 0;
      check(flags[3] == 1'b0, "R9", flags[3], 0);

      // R11: interrupt mask sweep with two flag patterns
      for (int pat = 0; pat < 2; pat++) begin
         logic [3:0] want_f;
         want_f = pat ? 4'b0100 : 4'b1111;
         @(negedge clk);
         ob_req = 1; ob_from_fifo = 1; fifo_empty = 1; ob_busy = !pat;
         fifo_overrun = !pat; ib_reg_wr = !pat; ib_busy = !pat;
         @(negedge clk);
         ob_req = 0; ob_from_fifo = 0; fifo_empty = 0; ob_busy = 0;
         fifo_overrun = 0; ib_reg_wr = 0; ib_busy = 0;
         check(flags == want_f, "R11", flags, want_f);
         for (int e = 0; e < 16; e++) begin
            bit wi;
            irq_en = 4'(e);
            wi = |(want_f & 4'(e));
            #1 check(irq == wi, "R11", irq, wi);
         end
         irq_en = 4'hF;
         clear_all();
      end

      @(negedge clk);
      check(flags == 4'h0, "R10", flags, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule